// File: doc/BRIEF.md
# Segmented Address Translator with Bounds and Permission Checking

This block turns a virtual address into a physical address using a small on-chip table of segments. The upper bits of the virtual address pick a segment. The lower bits are a byte displacement inside that segment. Each table slot describes one segment with four items: a present flag, three permission bits (read, write, execute), the last legal byte offset, and a physical start address. A lookup adds the start address to the displacement. A lookup is refused when the slot is empty, when the displacement runs past the last legal offset, or when the kind of access is not permitted. When a lookup is refused, exactly one fault line reports the most important reason.

The table is loaded through a separate write port. A load takes effect only when the writer states that it runs in supervisor mode. A load attempted from user mode changes nothing and raises a one-cycle privilege fault. Each lookup takes one cycle: a request presented before a clock edge returns its result on the registered outputs after that edge. Finding free physical memory for a segment, and compacting memory, are left to software.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table slot is empty and all outputs are low. Any lookup made before a supervisor load therefore reports an empty-slot fault.
- R2: A lookup with no fault returns, one cycle after the request, `resp_valid` high and `resp_paddr` equal to (slot start + displacement) modulo 2^PA_W. The segment number is `req_addr[31:28]` and the displacement is `req_addr[27:0]`.
- R3: A lookup into a slot whose present flag is 0 raises `flt_absent`.
- R4: In a present slot, a displacement strictly greater than the slot's last legal offset raises `flt_bounds`. A displacement equal to that offset is legal.
- R5: Access codes on `req_kind` are: 2'b00 read, 2'b01 write, 2'b10 instruction fetch, 2'b11 reserved. A read needs permission bit 0, a write needs bit 1 and a fetch needs bit 2. A lookup whose required bit is 0, or that uses the reserved code, raises `flt_perm`.
- R6: At most one fault line is high. The priority is empty slot first, then bounds, then permission.
- R7: A supervisor load (`ld_en` and `ld_super` high) writes the slot `ld_idx`. A lookup in the same cycle still sees the old contents. A lookup in the following cycle sees the new contents.
- R8: A load with `ld_super` low leaves the table unchanged and drives `flt_priv` high for exactly the following cycle.
- R9: A faulted response drives `resp_paddr` to 0. A cycle without a request gives `resp_valid`, every lookup fault line and `resp_paddr` all low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Virtual address: segment number in the top bits, displacement below |
| req_kind | input | 2 | Access type: read, write, fetch, reserved |
| ld_en | input | 1 | Table load strobe |
| ld_super | input | 1 | Writer is in supervisor mode |
| ld_idx | input | 4 | Slot to load |
| ld_present | input | 1 | New present flag |
| ld_perm | input | 3 | New permissions: bit 0 read, bit 1 write, bit 2 execute |
| ld_last | input | 28 | New last legal byte offset |
| ld_start | input | 28 | New physical start address |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_paddr | output | 28 | Physical address, 0 on any fault |
| flt_absent | output | 1 | Empty-slot fault |
| flt_bounds | output | 1 | Bounds fault |
| flt_perm | output | 1 | Permission fault |
| flt_priv | output | 1 | User-mode table load was refused |

## Verification
A slot that holds a corrupted start address gives a wrong `resp_paddr` on the first clean lookup into that slot. A corrupted last-offset value or permission field flips a fault line on the first lookup whose displacement or access type falls on the affected side of the check. In both cases the error shows one cycle after the request. A stray write from user mode shows up as a changed address or fault on any later lookup into that slot. The bench therefore checks the displacement exactly at the bound and one step on either side, and it reads slots back through normal lookups right after refused loads.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      KIND_READ  = 2'b00,
      KIND_WRITE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_RSVD  = 2'b11
   } kind_e;

   localparam int PERM_BITS = 3;
   localparam int PB_READ   = 0;
   localparam int PB_WRITE  = 1;
   localparam int PB_EXEC   = 2;

   typedef struct packed {
      logic absent;
      logic bounds;
      logic perm;
   } fault_t;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_W  = 4,
   parameter int DISP_W = 28,
   parameter int PA_W   = 28
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ld_en,
   input  logic                           ld_super,
   input  logic [SEG_W-1:0]               ld_idx,
   input  logic                           ld_present,
   input  logic [seg_pkg::PERM_BITS-1:0]  ld_perm,
   input  logic [DISP_W-1:0]              ld_last,
   input  logic [PA_W-1:0]                ld_start,
   input  logic [SEG_W-1:0]               rd_idx,
   output logic                           rd_present,
   output logic [seg_pkg::PERM_BITS-1:0]  rd_perm,
   output logic [DISP_W-1:0]              rd_last,
   output logic [PA_W-1:0]                rd_start
);
   localparam int SLOTS = 1 << SEG_W;

   logic                          pres_q  [SLOTS];
   logic [seg_pkg::PERM_BITS-1:0] perm_q  [SLOTS];
   logic [DISP_W-1:0]             last_q  [SLOTS];
   logic [PA_W-1:0]               start_q [SLOTS];

   logic ld_ok;
   assign ld_ok = ld_en && ld_super;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = ld_ok && (ld_idx == SEG_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q[s]  <= 1'b0;
            perm_q[s]  <= '0;
            last_q[s]  <= '0;
            start_q[s] <= '0;
         end else if (hit) begin
            pres_q[s]  <= ld_present;
            perm_q[s]  <= ld_perm;
            last_q[s]  <= ld_last;
            start_q[s] <= ld_start;
         end
      end

      // R8: a refused load leaves every slot untouched
      p_user_load_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_en && !ld_super) |=> ($stable(pres_q[s]) && $stable(perm_q[s])
                                   && $stable(last_q[s]) && $stable(start_q[s])));
   end

   assign rd_present = pres_q[rd_idx];
   assign rd_perm    = perm_q[rd_idx];
   assign rd_last    = last_q[rd_idx];
   assign rd_start   = start_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check #(
   parameter int DISP_W = 28
) (
   input  logic                           present,
   input  logic [seg_pkg::PERM_BITS-1:0]  perm,
   input  logic [DISP_W-1:0]              last,
   input  logic [DISP_W-1:0]              disp,
   input  seg_pkg::kind_e                 kind,
   output seg_pkg::fault_t                flt
);
   import seg_pkg::*;

   logic past_end;
   logic allowed;

   assign past_end = disp > last;

   always_comb begin
      unique case (kind)
         KIND_READ:  allowed = perm[PB_READ];
         KIND_WRITE: allowed = perm[PB_WRITE];
         KIND_FETCH: allowed = perm[PB_EXEC];
         default:    allowed = 1'b0;
      endcase
   end

   always_comb begin
      flt.absent = !present;
      flt.bounds = present && past_end;
      flt.perm   = present && !past_end && !allowed;
   end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int DISP_W = 28,
   parameter int PA_W   = 28
) (
   input  logic [PA_W-1:0]   start,
   input  logic [DISP_W-1:0] disp,
   output logic [PA_W-1:0]   sum
);
   logic [PA_W-1:0] disp_ext;

   if (PA_W > DISP_W) begin : g_widen
      assign disp_ext = {{(PA_W-DISP_W){1'b0}}, disp};
   end else begin : g_same
      assign disp_ext = disp;
   end

   assign sum = start + disp_ext;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
   parameter int SEG_W  = 4,
   parameter int DISP_W = 28,
   parameter int PA_W   = 28,
   localparam int ADDR_W = SEG_W + DISP_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [1:0]                    req_kind,
   input  logic                          ld_en,
   input  logic                          ld_super,
   input  logic [SEG_W-1:0]              ld_idx,
   input  logic                          ld_present,
   input  logic [2:0]                    ld_perm,
   input  logic [DISP_W-1:0]             ld_last,
   input  logic [PA_W-1:0]               ld_start,
   output logic                          resp_valid,
   output logic [PA_W-1:0]               resp_paddr,
   output logic                          flt_absent,
   output logic                          flt_bounds,
   output logic                          flt_perm,
   output logic                          flt_priv
);
   import seg_pkg::*;

   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("seg_xlate: SEG_W must lie in 1..8");
   end
   if (DISP_W > PA_W) begin : g_bad_disp
      $error("seg_xlate: DISP_W may not exceed PA_W");
   end
   if (PERM_BITS != 3) begin : g_bad_perm
      $error("seg_xlate: three permission bits expected");
   end

   logic [SEG_W-1:0]     seg;
   logic [DISP_W-1:0]    disp;
   logic                 t_present;
   logic [PERM_BITS-1:0] t_perm;
   logic [DISP_W-1:0]    t_last;
   logic [PA_W-1:0]      t_start;
   logic [PA_W-1:0]      sum;
   fault_t               chk;

   assign seg  = req_addr[ADDR_W-1 -: SEG_W];
   assign disp = req_addr[DISP_W-1:0];

   seg_table #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_super(ld_super), .ld_idx(ld_idx),
      .ld_present(ld_present), .ld_perm(ld_perm),
      .ld_last(ld_last), .ld_start(ld_start),
      .rd_idx(seg), .rd_present(t_present), .rd_perm(t_perm),
      .rd_last(t_last), .rd_start(t_start)
   );

   seg_check #(.DISP_W(DISP_W)) u_check (
      .present(t_present), .perm(t_perm), .last(t_last),
      .disp(disp), .kind(kind_e'(req_kind)), .flt(chk)
   );

   seg_adder #(.DISP_W(DISP_W), .PA_W(PA_W)) u_add (
      .start(t_start), .disp(disp), .sum(sum)
   );

   fault_t flt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_paddr <= '0;
         flt_q      <= '0;
         flt_priv   <= 1'b0;
      end else begin
         resp_valid <= req_valid;
         flt_priv   <= ld_en && !ld_super;
         if (req_valid) begin
            flt_q      <= chk;
            resp_paddr <= (|chk) ? '0 : sum;
         end else begin
            flt_q      <= '0;
            resp_paddr <= '0;
         end
      end
   end

   assign flt_absent = flt_q.absent;
   assign flt_bounds = flt_q.bounds;
   assign flt_perm   = flt_q.perm;

   // R2: one response per request, one cycle later
   p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (resp_valid == $past(req_valid)));

   // R4: a present slot overrun reported on the next cycle
   p_bounds_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && t_present && (disp > t_last)) |=> flt_bounds);

   // R6: never two fault reasons at once
   p_single_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flt_absent, flt_bounds, flt_perm}));

   // R8: refused load pulses the privilege flag
   p_priv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_super) |=> flt_priv);

   // R9: faulted response carries no address
   p_fault_no_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_absent || flt_bounds || flt_perm) |-> (resp_paddr == '0));

   // R9: idle cycle leaves outputs quiet
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (!flt_absent && !flt_bounds && !flt_perm && resp_paddr == '0));
endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        ld_en = 1'b0, ld_super = 1'b0, ld_present = 1'b0;
   logic [3:0]  ld_idx = '0;
   logic [2:0]  ld_perm = '0;
   logic [27:0] ld_last = '0, ld_start = '0;
   logic        resp_valid, flt_absent, flt_bounds, flt_perm, flt_priv;
   logic [27:0] resp_paddr;

   int n_chk = 0;
   int n_bad = 0;

   logic        m_pres  [16];
   logic [2:0]  m_perm  [16];
   logic [27:0] m_last  [16];
   logic [27:0] m_start [16];

   always #2.5 clk = ~clk;

   seg_xlate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .ld_en(ld_en), .ld_super(ld_super), .ld_idx(ld_idx),
      .ld_present(ld_present), .ld_perm(ld_perm), .ld_last(ld_last),
      .ld_start(ld_start), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
      .flt_absent(flt_absent), .flt_bounds(flt_bounds), .flt_perm(flt_perm),
      .flt_priv(flt_priv)
   );

   function automatic logic kind_ok(input logic [2:0] p, input logic [1:0] k);
      case (k)
         2'b00:   return p[0];
         2'b01:   return p[1];
         2'b10:   return p[2];
         default: return 1'b0;
      endcase
   endfunction

   // expected {valid, absent, bounds, perm, paddr} and requirement tag
   function automatic logic [31:0] predict(input logic rq, input logic [31:0] a,
                                           input logic [1:0] k, output string tag);
      logic [3:0]  s;
      logic [27:0] d;
      s = a[31:28];
      d = a[27:0];
      if (!rq) begin tag = "R9"; return 32'h0; end
      if (!m_pres[s]) begin tag = "R3"; return {4'b1100, 28'h0}; end
      if (d > m_last[s]) begin tag = "R4"; return {4'b1010, 28'h0}; end
      if (!kind_ok(m_perm[s], k)) begin tag = "R5"; return {4'b1001, 28'h0}; end
      tag = "R2";
      return {4'b1000, m_start[s] + d};
   endfunction

   task automatic step(input logic rq, input logic [31:0] a, input logic [1:0] k,
                       input logic we, input logic ws, input logic [3:0] wi,
                       input logic wp_pres, input logic [2:0] wp, input logic [27:0] wl,
                       input logic [27:0] wb, input string force_tag);
      string       tag;
      logic [31:0] exp_v, got_v;
      exp_v = predict(rq, a, k, tag);
      if (force_tag != "") tag = force_tag;
      req_valid = rq; req_addr = a; req_kind = k;
      ld_en = we; ld_super = ws; ld_idx = wi; ld_present = wp_pres;
      ld_perm = wp; ld_last = wl; ld_start = wb;
      @(posedge clk);
      #1;
      if (we && ws) begin
         m_pres[wi] = wp_pres; m_perm[wi] = wp; m_last[wi] = wl; m_start[wi] = wb;
      end
      got_v = {resp_valid, flt_absent, flt_bounds, flt_perm, resp_paddr};
      n_chk++;
      if (got_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s resp: got %h expected %h", tag, got_v, exp_v);
      end
      if (we) begin
         n_chk++;
         if (flt_priv !== !ws) begin
            n_bad++;
            $display("FAIL R8 priv flag: got %b expected %b", flt_priv, !ws);
         end
      end
   endtask

   task automatic look(input logic [3:0] s, input logic [27:0] d, input logic [1:0] k,
                       input string t);
      step(1'b1, {s, d}, k, 1'b0, 1'b0, 4'h0, 1'b0, 3'h0, 28'h0, 28'h0, t);
   endtask

   task automatic load(input logic ws, input logic [3:0] s, input logic p,
                       input logic [2:0] pm, input logic [27:0] l, input logic [27:0] b,
                       input string t);
      step(1'b0, 32'h0, 2'b00, 1'b1, ws, s, p, pm, l, b, t);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_pres[i] = 1'b0; m_perm[i] = '0; m_last[i] = '0; m_start[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1;
      n_chk++;
      if ({resp_valid, flt_absent, flt_bounds, flt_perm, flt_priv, resp_paddr} !== '0) begin
         n_bad++;
         $display("FAIL R1 reset outputs: got %b expected 0",
                  {resp_valid, flt_absent, flt_bounds, flt_perm, flt_priv});
      end
      rst_n = 1'b1;
      // R1: all slots empty after reset
      for (int s = 0; s < 16; s++) look(4'(s), 28'h0, 2'b00, "R1");

      // R4 boundary: last legal offset 0xFF in a read-only slot
      load(1'b1, 4'd2, 1'b1, 3'b001, 28'h0FF, 28'h1000000, "");
      look(4'd2, 28'h0FF, 2'b00, "R4");
      look(4'd2, 28'h0FE, 2'b00, "R4");
      look(4'd2, 28'h100, 2'b00, "R4");
      // R5: write and fetch refused, reserved code refused
      look(4'd2, 28'h010, 2'b01, "R5");
      look(4'd2, 28'h010, 2'b10, "R5");
      load(1'b1, 4'd3, 1'b1, 3'b111, 28'hFFFFFFF, 28'h0, "");
      look(4'd3, 28'h123, 2'b11, "R5");
      look(4'd3, 28'h123, 2'b10, "R5");

      // R8: user load refused, then slot 2 still answers with old start
      load(1'b0, 4'd2, 1'b1, 3'b111, 28'hFFFFFFF, 28'h0ABCDEF, "");
      look(4'd2, 28'h020, 2'b00, "R8");
      look(4'd2, 28'h200, 2'b00, "R8");
      load(1'b0, 4'd9, 1'b1, 3'b111, 28'hFFFFFFF, 28'h0, "");
      look(4'd9, 28'h0, 2'b00, "R8");

      // R7: load and lookup in the same cycle see old contents, next sees new
      step(1'b1, {4'd5, 28'h40}, 2'b00, 1'b1, 1'b1, 4'd5, 1'b1, 3'b001, 28'hFFF,
           28'h0200000, "R7");
      look(4'd5, 28'h40, 2'b00, "R7");

      // R6: bounds beats permission; absent beats both
      load(1'b1, 4'd6, 1'b1, 3'b000, 28'h10, 28'h5000, "");
      look(4'd6, 28'h20, 2'b01, "R6");
      look(4'd6, 28'h08, 2'b01, "R6");
      look(4'd7, 28'hFFFFFFF, 2'b11, "R6");
      // absent slot reloaded as not present
      load(1'b1, 4'd6, 1'b0, 3'b111, 28'hFFFFFFF, 28'h5000, "");
      look(4'd6, 28'h0, 2'b00, "R3");

      // R2: wrap of start plus displacement
      load(1'b1, 4'd8, 1'b1, 3'b010, 28'hFFFFFFF, 28'hFFFFFF0, "");
      look(4'd8, 28'h20, 2'b01, "R2");

      // R9: idle cycle
      step(1'b0, 32'hFFFFFFFF, 2'b01, 1'b0, 1'b0, 4'h0, 1'b0, 3'h0, 28'h0, 28'h0, "R9");

      // random mix, fixed seed
      void'($urandom(32'd20240611));
      for (int n = 0; n < 4000; n++) begin
         logic        rq, we, ws, wpres;
         logic [3:0]  s, wi;
         logic [27:0] d, wl;
         logic [1:0]  k;
         rq = ($urandom % 4) != 0;
         we = ($urandom % 4) == 0;
         ws = ($urandom % 4) != 0;
         wi = 4'($urandom);
         wpres = ($urandom % 8) != 0;
         wl = ($urandom % 2) ? 28'($urandom % 512) : 28'($urandom);
         s = 4'($urandom);
         k = 2'($urandom);
         if ($urandom % 2) d = m_last[s] + 28'($urandom % 4) - 28'd1;
         else              d = 28'($urandom);
         step(rq, {s, d}, k, we, ws, wi, wpres, 3'($urandom), wl, 28'($urandom), "");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule